// File: doc/BRIEF.md
# Multicycle Instruction Sequencing Controller

This block sequences one instruction at a time for a small processor with a 16-bit word and eight general registers. It keeps a copy of the instruction word in its own instruction register. When told to start, it decodes the opcode and operation fields of that word. It then steps through operand fetch, an execute state specific to the operation, and write-back. In each state it drives the control strobes of an external datapath: which register to read or write, which operand latch or result latch to load, what the ALU and shifter should do, which source feeds the register write port, and whether the status flags should be updated.

An idle output tells the surrounding logic that the controller is waiting for its next start. The immediate move goes straight from decode to a write of the sign-extended 8-bit constant. Compare fetches both operands, updates the flags and returns to idle with no write-back. Every control output is registered. Each one reflects the current state and the current content of the instruction register.

Top module: `seqc_top`

## Requirements
- R1: A synchronous, active-high reset puts the controller in the idle state (state code 0000) with `idle` high, every strobe low and the instruction register cleared, so `imm_ext` reads 0.
- R2: In the idle state the controller stays put while `start` is low, and moves to the decode state (code 0001) on the first clock edge where `start` is high.
- R3: `idle` is 1 in the idle state and 0 in every other state.
- R4: The instruction register takes `instr_in` on every clock edge where `load` is high, in any state. Fields: opcode [15:13], op [12:11], Rn [10:8], Rd [7:5], shift [4:3], Rm [2:0], immediate [7:0].
- R5: Opcode 110 with op 10 runs decode, then the immediate-write state (1010), then idle. In the immediate-write state `wr_sel`=Rn, `reg_we`=1 and `src_imm`=1. At all times `imm_ext` is bits [7:0] of the instruction register, sign-extended to the data width.
- R6: Opcode 110 with op 00, and opcode 101 with op 00, 10 or 11, run decode (0001), operand A (0010), operand B (0011), then an execute state, then register write-back (1001), then idle. The execute states are register move 0100, add 0101, and 0111 and invert 1000.
- R7: Opcode 101 with op 01 runs decode, operand A, operand B, then the compare state (0110), then idle. `flag_ld` is 1 only in the compare state, and `reg_we` stays 0 throughout.
- R8: The operand A state drives `rd_sel`=Rn with `ld_a`=1. The operand B state drives `rd_sel`=Rm with `ld_b`=1.
- R9: Execute states assert `ld_c`. `alu_op` is 00 for add and register move, 01 for compare, 10 for and, and 11 for invert. `sh_op` equals the shift field in all execute and compare states. `a_bypass` is 1 only in the register-move state.
- R10: In the register write-back state `wr_sel`=Rd, `reg_we`=1 and `src_imm`=0.
- R11: In decode, any opcode/op pair not listed in R5 to R7 returns to idle on the next edge and asserts no strobe.
- R12: A reset raised in any state returns the controller to idle on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing the held instruction |
| load | input | 1 | Capture `instr_in` into the instruction register |
| instr_in | input | INSN_W | Instruction word |
| state_code | output | 4 | Current state code |
| idle | output | 1 | High only in the idle state |
| rd_sel | output | 3 | Register read select |
| wr_sel | output | 3 | Register write select |
| reg_we | output | 1 | Register file write enable |
| src_imm | output | 1 | Write source: 1 = sign-extended immediate, 0 = datapath result |
| ld_a | output | 1 | Load operand A latch |
| ld_b | output | 1 | Load operand B latch |
| ld_c | output | 1 | Load result latch |
| a_bypass | output | 1 | Force operand A to zero (register move) |
| alu_op | output | 2 | ALU operation code |
| sh_op | output | 2 | Shifter operation for operand B |
| flag_ld | output | 1 | Load status flags |
| imm_ext | output | DATA_W | Sign-extended immediate field |

## Verification
The bench builds the controller with its default sizes: a 16-bit instruction word and a 16-bit data width. With these sizes the immediate extension is checked with both a positive constant and one whose top bit is set. A behavioural model compares every output on every cycle. The stimulus covers each operation and several undefined opcode/op pairs. It also reloads the instruction register in the middle of an instruction, holds start high back to back, and applies reset in the middle of execution.

// File: rtl/seqc_pkg.sv
package seqc_pkg;
  localparam int INSN_W  = 16;
  localparam int OPC_W   = 3;
  localparam int OPF_W   = 2;
  localparam int RSEL_W  = 3;
  localparam int SH_W    = 2;
  localparam int IMM_W   = 8;
  localparam int ST_W    = 4;
  localparam int ALU_W   = 2;

  // field positions decoded by the datapath and this controller
  localparam int OPC_LSB = 13;
  localparam int OPF_LSB = 11;
  localparam int RN_LSB  = 8;
  localparam int RD_LSB  = 5;
  localparam int SH_LSB  = 3;
  localparam int RM_LSB  = 0;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 4'd0,
    ST_DEC  = 4'd1,
    ST_RDA  = 4'd2,
    ST_RDB  = 4'd3,
    ST_XMOV = 4'd4,
    ST_XADD = 4'd5,
    ST_XCMP = 4'd6,
    ST_XAND = 4'd7,
    ST_XMVN = 4'd8,
    ST_WBR  = 4'd9,
    ST_WBI  = 4'd10
  } state_e;

  localparam logic [OPC_W-1:0] OPC_MOVE = 3'b110;
  localparam logic [OPC_W-1:0] OPC_ARTH = 3'b101;
  localparam logic [OPF_W-1:0] OPF_MREG = 2'b00;
  localparam logic [OPF_W-1:0] OPF_MIMM = 2'b10;

  localparam logic [ALU_W-1:0] ALU_ADD = 2'b00;
  localparam logic [ALU_W-1:0] ALU_SUB = 2'b01;
  localparam logic [ALU_W-1:0] ALU_AND = 2'b10;
  localparam logic [ALU_W-1:0] ALU_INV = 2'b11;

  // execute state chosen by the operation fields, ST_IDLE if undefined
  function automatic state_e exec_of(input logic [OPC_W-1:0] opc,
                                     input logic [OPF_W-1:0] opf);
    state_e r;
    r = ST_IDLE;
    if (opc == OPC_MOVE && opf == OPF_MREG) r = ST_XMOV;
    else if (opc == OPC_ARTH) begin
      unique case (opf)
        2'b00:   r = ST_XADD;
        2'b01:   r = ST_XCMP;
        2'b10:   r = ST_XAND;
        default: r = ST_XMVN;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/seqc_ir.sv
module seqc_ir
  import seqc_pkg::*;
#(
  parameter int W = INSN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [W-1:0]      instr_in,
  output logic [OPC_W-1:0]  q_opc,
  output logic [OPF_W-1:0]  q_opf,
  output logic [RSEL_W-1:0] d_rn,
  output logic [RSEL_W-1:0] d_rd,
  output logic [SH_W-1:0]   d_sh,
  output logic [RSEL_W-1:0] d_rm,
  output logic [IMM_W-1:0]  d_imm
);
  logic [W-1:0] ir_q;
  logic [W-1:0] ir_d;

  always_comb begin
    ir_d = ir_q;
    if (load) ir_d = instr_in;
    if (rst)  ir_d = '0;
  end

  always_ff @(posedge clk) begin
    ir_q <= ir_d;
  end

  assign q_opc = ir_q[OPC_LSB +: OPC_W];
  assign q_opf = ir_q[OPF_LSB +: OPF_W];
  assign d_rn  = ir_d[RN_LSB +: RSEL_W];
  assign d_rd  = ir_d[RD_LSB +: RSEL_W];
  assign d_sh  = ir_d[SH_LSB +: SH_W];
  assign d_rm  = ir_d[RM_LSB +: RSEL_W];
  assign d_imm = ir_d[IMM_W-1:0];
endmodule

// File: rtl/seqc_fsm.sv
module seqc_fsm
  import seqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OPC_W-1:0] opc,
  input  logic [OPF_W-1:0] opf,
  output state_e           state_q,
  output state_e           state_d
);
  logic   is_imm;
  state_e x_st;

  assign is_imm = (opc == OPC_MOVE) && (opf == OPF_MIMM);
  assign x_st   = exec_of(opc, opf);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_DEC;
      ST_DEC: begin
        if (is_imm)                 state_d = ST_WBI;
        else if (x_st != ST_IDLE)   state_d = ST_RDA;
        else                        state_d = ST_IDLE;
      end
      ST_RDA:  state_d = ST_RDB;
      ST_RDB:  state_d = x_st;
      ST_XMOV, ST_XADD, ST_XAND, ST_XMVN: state_d = ST_WBR;
      ST_XCMP, ST_WBR, ST_WBI: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (rst) state_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    state_q <= state_d;
  end
endmodule

// File: rtl/seqc_ctl.sv
module seqc_ctl
  import seqc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  state_e            state_d,
  input  logic [RSEL_W-1:0] rn,
  input  logic [RSEL_W-1:0] rd,
  input  logic [SH_W-1:0]   sh,
  input  logic [RSEL_W-1:0] rm,
  input  logic [IMM_W-1:0]  imm,
  output logic              idle,
  output logic [RSEL_W-1:0] rd_sel,
  output logic [RSEL_W-1:0] wr_sel,
  output logic              reg_we,
  output logic              src_imm,
  output logic              ld_a,
  output logic              ld_b,
  output logic              ld_c,
  output logic              a_bypass,
  output logic [ALU_W-1:0]  alu_op,
  output logic [SH_W-1:0]   sh_op,
  output logic              flag_ld,
  output logic [DW-1:0]     imm_ext
);
  localparam int EXT_W = DW - IMM_W;

  logic              n_idle, n_we, n_src, n_la, n_lb, n_lc, n_byp, n_fl;
  logic [RSEL_W-1:0] n_rs, n_ws;
  logic [ALU_W-1:0]  n_alu;
  logic [SH_W-1:0]   n_sh;

  always_comb begin
    n_idle = 1'b0; n_we = 1'b0; n_src = 1'b0; n_la = 1'b0; n_lb = 1'b0;
    n_lc   = 1'b0; n_byp = 1'b0; n_fl = 1'b0;
    n_rs   = '0; n_ws = '0; n_alu = ALU_ADD; n_sh = '0;
    unique case (state_d)
      ST_IDLE: n_idle = 1'b1;
      ST_RDA:  begin n_rs = rn; n_la = 1'b1; end
      ST_RDB:  begin n_rs = rm; n_lb = 1'b1; end
      ST_XMOV: begin n_lc = 1'b1; n_byp = 1'b1; n_alu = ALU_ADD; n_sh = sh; end
      ST_XADD: begin n_lc = 1'b1; n_alu = ALU_ADD; n_sh = sh; end
      ST_XCMP: begin n_fl = 1'b1; n_alu = ALU_SUB; n_sh = sh; end
      ST_XAND: begin n_lc = 1'b1; n_alu = ALU_AND; n_sh = sh; end
      ST_XMVN: begin n_lc = 1'b1; n_alu = ALU_INV; n_sh = sh; end
      ST_WBR:  begin n_ws = rd; n_we = 1'b1; end
      ST_WBI:  begin n_ws = rn; n_we = 1'b1; n_src = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idle <= 1'b1; reg_we <= 1'b0; src_imm <= 1'b0; ld_a <= 1'b0;
      ld_b <= 1'b0; ld_c <= 1'b0; a_bypass <= 1'b0; flag_ld <= 1'b0;
      rd_sel <= '0; wr_sel <= '0; alu_op <= ALU_ADD; sh_op <= '0;
      imm_ext <= '0;
    end else begin
      idle <= n_idle; reg_we <= n_we; src_imm <= n_src; ld_a <= n_la;
      ld_b <= n_lb; ld_c <= n_lc; a_bypass <= n_byp; flag_ld <= n_fl;
      rd_sel <= n_rs; wr_sel <= n_ws; alu_op <= n_alu; sh_op <= n_sh;
      imm_ext <= {{EXT_W{imm[IMM_W-1]}}, imm};
    end
  end
endmodule

// File: rtl/seqc_top.sv
module seqc_top
  import seqc_pkg::*;
#(
  parameter int INSN_W_P = INSN_W,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                load,
  input  logic [INSN_W_P-1:0] instr_in,
  output logic [ST_W-1:0]     state_code,
  output logic                idle,
  output logic [RSEL_W-1:0]   rd_sel,
  output logic [RSEL_W-1:0]   wr_sel,
  output logic                reg_we,
  output logic                src_imm,
  output logic                ld_a,
  output logic                ld_b,
  output logic                ld_c,
  output logic                a_bypass,
  output logic [ALU_W-1:0]    alu_op,
  output logic [SH_W-1:0]     sh_op,
  output logic                flag_ld,
  output logic [DATA_W-1:0]   imm_ext
);
  logic [OPC_W-1:0]  q_opc;
  logic [OPF_W-1:0]  q_opf;
  logic [RSEL_W-1:0] d_rn, d_rd, d_rm;
  logic [SH_W-1:0]   d_sh;
  logic [IMM_W-1:0]  d_imm;
  state_e            st_q, st_d;

  seqc_ir #(.W(INSN_W_P)) u_ir (
    .clk(clk), .rst(rst), .load(load), .instr_in(instr_in),
    .q_opc(q_opc), .q_opf(q_opf), .d_rn(d_rn), .d_rd(d_rd),
    .d_sh(d_sh), .d_rm(d_rm), .d_imm(d_imm)
  );

  seqc_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .opc(q_opc), .opf(q_opf),
    .state_q(st_q), .state_d(st_d)
  );

  seqc_ctl #(.DW(DATA_W)) u_ctl (
    .clk(clk), .rst(rst), .state_d(st_d), .rn(d_rn), .rd(d_rd),
    .sh(d_sh), .rm(d_rm), .imm(d_imm), .idle(idle), .rd_sel(rd_sel),
    .wr_sel(wr_sel), .reg_we(reg_we), .src_imm(src_imm), .ld_a(ld_a),
    .ld_b(ld_b), .ld_c(ld_c), .a_bypass(a_bypass), .alu_op(alu_op),
    .sh_op(sh_op), .flag_ld(flag_ld), .imm_ext(imm_ext)
  );

  assign state_code = st_q;
endmodule

// File: rtl/seqc_chk.sv
module seqc_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [3:0] state_code,
  input logic       idle,
  input logic       reg_we,
  input logic       src_imm,
  input logic       flag_ld,
  input logic       ld_a,
  input logic       ld_b,
  input logic       ld_c
);
  // R1 R12
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (state_code == 4'd0 && idle && !reg_we));

  // R2
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'd0 && !start) |=> state_code == 4'd0);

  // R2
  wait_go_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'd0 && start) |=> state_code == 4'd1);

  // R3
  idle_only_wait_chk: assert property (@(posedge clk) disable iff (rst)
    idle == (state_code == 4'd0));

  // R7
  cmp_exit_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 4'd6 |=> state_code == 4'd0);

  // R7
  flag_only_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    flag_ld |-> state_code == 4'd6);

  // R5
  imm_write_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 4'd10 |-> (reg_we && src_imm));

  // R10
  reg_write_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 4'd9 |-> (reg_we && !src_imm));

  // R8
  fetch_order_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 4'd2 |=> state_code == 4'd3);

  // R8
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_a, ld_b, ld_c, reg_we, flag_ld}));
endmodule

bind seqc_top seqc_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .state_code(state_code),
  .idle(idle), .reg_we(reg_we), .src_imm(src_imm), .flag_ld(flag_ld),
  .ld_a(ld_a), .ld_b(ld_b), .ld_c(ld_c)
);

// File: tb/test_seqc_top.sv
`timescale 1ns/1ps
module test_seqc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        load = 1'b0;
  logic [15:0] instr_in = '0;
  logic [3:0]  state_code;
  logic        idle, reg_we, src_imm, ld_a, ld_b, ld_c, a_bypass, flag_ld;
  logic [2:0]  rd_sel, wr_sel;
  logic [1:0]  alu_op, sh_op;
  logic [15:0] imm_ext;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // model state
  int          ms = 0;
  logic [15:0] mir = '0;

  seqc_top i_seqc_top (
    .clk(clk), .rst(rst), .start(start), .load(load), .instr_in(instr_in),
    .state_code(state_code), .idle(idle), .rd_sel(rd_sel), .wr_sel(wr_sel),
    .reg_we(reg_we), .src_imm(src_imm), .ld_a(ld_a), .ld_b(ld_b),
    .ld_c(ld_c), .a_bypass(a_bypass), .alu_op(alu_op), .sh_op(sh_op),
    .flag_ld(flag_ld), .imm_ext(imm_ext)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int next_of(input int s, input logic st, input logic [15:0] ir);
    int opc = int'(ir[15:13]);
    int op  = int'(ir[12:11]);
    bit mvr = (opc == 6 && op == 0);
    case (s)
      0: return st ? 1 : 0;
      1: begin
        if (opc == 6 && op == 2) return 10;
        if (mvr || opc == 5) return 2;
        return 0;
      end
      2: return 3;
      3: begin
        if (mvr) return 4;
        if (opc == 5) return (op == 0) ? 5 : (op == 1) ? 6 : (op == 2) ? 7 : 8;
        return 0;
      end
      4, 5, 7, 8: return 9;
      default: return 0;
    endcase
  endfunction

  task automatic compare_all();
    int rn = int'(mir[10:8]);
    int rd = int'(mir[7:5]);
    int sh = int'(mir[4:3]);
    int rm = int'(mir[2:0]);
    int e_rs = 0, e_ws = 0, e_we = 0, e_src = 0, e_la = 0, e_lb = 0;
    int e_lc = 0, e_byp = 0, e_alu = 0, e_sh = 0, e_fl = 0;
    int e_imm = int'({{8{mir[7]}}, mir[7:0]});
    case (ms)
      2: begin e_rs = rn; e_la = 1; end
      3: begin e_rs = rm; e_lb = 1; end
      4: begin e_lc = 1; e_byp = 1; e_sh = sh; end
      5: begin e_lc = 1; e_sh = sh; end
      6: begin e_fl = 1; e_alu = 1; e_sh = sh; end
      7: begin e_lc = 1; e_alu = 2; e_sh = sh; end
      8: begin e_lc = 1; e_alu = 3; e_sh = sh; end
      9: begin e_ws = rd; e_we = 1; end
      10: begin e_ws = rn; e_we = 1; e_src = 1; end
      default: ;
    endcase
    chk("R2 R6", "state_code", int'(state_code), ms);
    chk("R3", "idle", int'(idle), (ms == 0) ? 1 : 0);
    chk("R8", "rd_sel", int'(rd_sel), e_rs);
    chk("R8", "ld_a", int'(ld_a), e_la);
    chk("R8", "ld_b", int'(ld_b), e_lb);
    chk("R10 R5", "wr_sel", int'(wr_sel), e_ws);
    chk("R10 R5", "reg_we", int'(reg_we), e_we);
    chk("R10 R5", "src_imm", int'(src_imm), e_src);
    chk("R9", "ld_c", int'(ld_c), e_lc);
    chk("R9", "a_bypass", int'(a_bypass), e_byp);
    chk("R9", "alu_op", int'(alu_op), e_alu);
    chk("R9", "sh_op", int'(sh_op), e_sh);
    chk("R7", "flag_ld", int'(flag_ld), e_fl);
    chk("R5 R4", "imm_ext", int'(imm_ext), e_imm);
  endtask

  // drive one cycle's inputs (at a falling edge), advance model and DUT, compare
  task automatic cyc(input logic s, input logic l, input logic [15:0] w, input logic r);
    int nx;
    start = s; load = l; instr_in = w; rst = r;
    nx = next_of(ms, s, mir);
    if (l) mir = w;
    if (r) begin nx = 0; mir = '0; end
    ms = nx;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic run_insn(input logic [15:0] w);
    cyc(1'b0, 1'b1, w, 1'b0);
    cyc(1'b1, 1'b0, 16'h0, 1'b0);
    for (int k = 0; k < 8 && ms != 0; k++) cyc(1'b0, 1'b0, 16'h0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(1'b0, 1'b0, 16'h0, 1'b1);
    cyc(1'b0, 1'b0, 16'h0, 1'b1);
    // R1 reset state
    chk("R1", "reset state", int'(state_code), 0);
    chk("R1", "reset idle", int'(idle), 1);
    chk("R1", "reset imm", int'(imm_ext), 0);
    // R2 hold in idle
    repeat (3) cyc(1'b0, 1'b0, 16'h0, 1'b0);
    chk("R2", "hold idle", int'(state_code), 0);
    // R4 load in idle without start changes only the held word
    cyc(1'b0, 1'b1, 16'hD07F, 1'b0);
    chk("R4", "loaded imm", int'(imm_ext), 16'h007F);
    chk("R4", "still idle", int'(state_code), 0);
    // R5 immediate moves, positive and negative constants
    run_insn(16'hD007);
    run_insn(16'hD381);
    chk("R5", "neg imm", int'(imm_ext), 16'hFF81);
    // R6 R9 R10 register operations
    run_insn(16'hA148);
    run_insn(16'hC062);
    run_insn(16'hB081);
    run_insn(16'hB8BC);
    // R7 compare
    run_insn(16'hAD1C);
    chk("R7", "cmp back idle", int'(state_code), 0);
    // R11 undefined combinations
    run_insn(16'h1234);
    run_insn(16'hC8FF);
    run_insn(16'hE000);
    run_insn(16'hD800);
    chk("R11", "undef idle", int'(state_code), 0);
    // R4 reload during operand fetch steers later states
    cyc(1'b0, 1'b1, 16'hA148, 1'b0);
    cyc(1'b1, 1'b0, 16'h0, 1'b0);
    cyc(1'b0, 1'b0, 16'h0, 1'b0);
    cyc(1'b0, 1'b1, 16'hAE15, 1'b0);
    chk("R4", "rd_sel from new word", int'(rd_sel), 5);
    for (int k = 0; k < 6 && ms != 0; k++) cyc(1'b0, 1'b0, 16'h0, 1'b0);
    // start held high back to back
    cyc(1'b0, 1'b1, 16'hD2AA, 1'b0);
    repeat (7) cyc(1'b1, 1'b0, 16'h0, 1'b0);
    cyc(1'b0, 1'b0, 16'h0, 1'b0);
    // R12 reset mid-execution
    cyc(1'b0, 1'b1, 16'hA148, 1'b0);
    cyc(1'b1, 1'b0, 16'h0, 1'b0);
    cyc(1'b0, 1'b0, 16'h0, 1'b0);
    cyc(1'b0, 1'b0, 16'h0, 1'b0);
    cyc(1'b0, 1'b0, 16'h0, 1'b1);
    chk("R12", "reset mid-run", int'(state_code), 0);
    cyc(1'b0, 1'b0, 16'h0, 1'b0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule